// File: doc/BRIEF.md
# Scaled Fractional System Counter

This block keeps the system time base for a chip. The count sits in an 88-bit fixed-point accumulator. The upper 64 bits are the visible count and the lower 24 bits are a fraction. On every cycle where the tick input is high and the counter is running, the accumulator grows by one of two amounts:

- exactly one whole count, or
- a programmable 8.24 fixed-point step.

The programmable step lets the visible count advance at a rate that is not a whole multiple of the tick rate.

Software reaches the block through a 32-bit word interface with two register frames, picked by a frame select bit.

- **Control frame:**
  - offset 0: control word;
  - offset 1: step (scale) register;
  - offset 2: low half of the count;
  - offset 3: high half of the count.
- **Status frame:** read-only.
  - offset 0: low half of the count;
  - offset 1: high half of the count.

Reading the low half of the count, from either frame, captures the high half at that moment. Later reads of the high half return that captured value, so software reading low then high never sees a torn value across a carry. A read gets its response on the cycle after the request.

Top module: `sysctr_top`

## Requirements
- R1: After reset the control word reads 0, the scale register reads 0x01000000, both count halves read 0, and no response is pending.
- R2: While control bit 0 (run) is 0, ticks leave the count unchanged.
- R3: While run is 1 and control bit 2 (scale enable) is 0, each tick adds 0x01000000 fraction units to the accumulator, which is one visible count.
- R4: While run is 1 and scale enable is 1, each tick adds the scale register value to the 88-bit accumulator. The visible count is accumulator bits 87:24, and the fraction carries into it.
- R5: A write to the scale register (control offset 1) takes effect only when run is 0. While run is 1 the write is dropped and the old value still reads back.
- R6: A write to control offset 2 replaces count bits 31:0, and a write to offset 3 replaces count bits 63:32. Each write leaves the other half as it was, clears the fraction, and wins over a tick in the same cycle.
- R7: A read of the low count half returns the live bits 31:0 and captures bits 63:32. A read of the high half, in either frame, returns the most recent capture, which is 0 after reset.
- R8: Control bits 1 and 3 are stored and read back but do not change counting. The clock switch field, control bits 9:8, always reads 0. Every other control bit reads 0.
- R9: The status frame returns the count halves at offset 0 (low) and offset 1 (high). Writes to the status frame change nothing.
- R10: A read request gives rsp_valid high with data on the next cycle. A write gives no response. A read of an unused offset returns 0.
- R11: The accumulator wraps modulo 2^88, so the visible count wraps from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable strobe, one step per high cycle |
| req_valid | input | 1 | Register access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_frame | input | 1 | 0 = control frame, 1 = status frame |
| req_addr | input | ADDR_W | Word offset inside the frame |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | DATA_W | Read response data |

## Verification
The assertions assume that at most one request arrives per cycle, and that each request is sampled only on the edge where req_valid is high. They also take tick to be a plain synchronous enable whose value is sampled at the edge. The bench holds to this by changing every input only on the falling clock edge and by issuing one request at a time with idle cycles between them. Tick patterns are constant high, constant low, or a pseudo-random sequence. The step checks also assume that a count half write and a tick can coincide, so the accumulator properties are gated on the absence of a half write.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;
  // control word bit map
  localparam int CTRL_RUN_BIT    = 0;
  localparam int CTRL_IRQEN_BIT  = 1;
  localparam int CTRL_SCALE_BIT  = 2;
  localparam int CTRL_IRQMSK_BIT = 3;
  localparam int CTRL_KEEP_W     = 4;
  localparam int CTRL_CLKSW_LSB  = 8;   // two-bit clock switch field, reads 0

  // word offsets
  localparam int OFF_CTRL     = 0;
  localparam int OFF_SCALE    = 1;
  localparam int OFF_CNT_BASE = 2;
  localparam int STS_CNT_BASE = 0;

  localparam logic FRAME_CTRL = 1'b0;
  localparam logic FRAME_STAT = 1'b1;
endpackage

// File: rtl/sysctr_ctrl_regs.sv
module sysctr_ctrl_regs
  import sysctr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SCALE_W = 32,
  parameter logic [SCALE_W-1:0] SCALE_RST = 32'h0100_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_we,
  input  logic               scale_we,
  input  logic [DATA_W-1:0]  wdata,
  output logic               run,
  output logic               scale_en,
  output logic [DATA_W-1:0]  ctrl_word,
  output logic [SCALE_W-1:0] scale
);
  logic [CTRL_KEEP_W-1:0] keep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      keep_q <= '0;
    end else if (ctrl_we) begin
      keep_q <= wdata[CTRL_KEEP_W-1:0];
    end
  end

  // step register is locked while the counter runs
  always_ff @(posedge clk) begin
    if (rst) begin
      scale <= SCALE_RST;
    end else if (scale_we && !keep_q[CTRL_RUN_BIT]) begin
      scale <= wdata[SCALE_W-1:0];
    end
  end

  assign run      = keep_q[CTRL_RUN_BIT];
  assign scale_en = keep_q[CTRL_SCALE_BIT];

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_KEEP_W-1:0] = keep_q;
  end
endmodule

// File: rtl/sysctr_accum.sv
module sysctr_accum #(
  parameter int INT_W   = 64,
  parameter int FRAC_W  = 24,
  parameter int DATA_W  = 32,
  parameter int SCALE_W = 32,
  localparam int ACC_W      = INT_W + FRAC_W,
  localparam int NUM_HALVES = INT_W / DATA_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  run,
  input  logic                  scale_en,
  input  logic [SCALE_W-1:0]    scale,
  input  logic [NUM_HALVES-1:0] half_we,
  input  logic [DATA_W-1:0]     wdata,
  output logic [INT_W-1:0]      count,
  output logic [ACC_W-1:0]      acc
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step;
  logic [INT_W-1:0] wr_int;

  // each half is either replaced by the write data or kept
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    assign wr_int[h*DATA_W +: DATA_W] =
      half_we[h] ? wdata : acc_q[FRAC_W + h*DATA_W +: DATA_W];
  end

  assign step = scale_en ? ACC_W'(scale) : (ACC_W'(1) << FRAC_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (|half_we) begin
      acc_q <= {wr_int, {FRAC_W{1'b0}}};
    end else if (run && tick) begin
      acc_q <= acc_q + step;
    end
  end

  assign count = acc_q[ACC_W-1:FRAC_W];
  assign acc   = acc_q;
endmodule

// File: rtl/sysctr_readout.sv
module sysctr_readout
  import sysctr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INT_W  = 64,
  parameter int ADDR_W = 4,
  localparam int NUM_HALVES = INT_W / DATA_W,
  localparam int HIDX_W     = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              rd_frame,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] ctrl_word,
  input  logic [DATA_W-1:0] scale_word,
  input  logic [INT_W-1:0]  count,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [INT_W-DATA_W-1:0] snap_q;
  logic [INT_W-1:0]        view;
  logic                    hit_half;
  logic [HIDX_W-1:0]       half_idx;
  logic [DATA_W-1:0]       rd_data;
  int                      cnt_base;

  // low half is always live; upper halves come from the capture
  assign view = {snap_q, count[DATA_W-1:0]};

  always_comb begin
    cnt_base = (rd_frame == FRAME_CTRL) ? OFF_CNT_BASE : STS_CNT_BASE;
    hit_half = 1'b0;
    half_idx = '0;
    for (int h = 0; h < NUM_HALVES; h++) begin
      if (rd_addr == ADDR_W'(cnt_base + h)) begin
        hit_half = 1'b1;
        half_idx = HIDX_W'(h);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit_half) begin
      rd_data = view[int'(half_idx)*DATA_W +: DATA_W];
    end else if (rd_frame == FRAME_CTRL) begin
      if (rd_addr == ADDR_W'(OFF_CTRL))  rd_data = ctrl_word;
      if (rd_addr == ADDR_W'(OFF_SCALE)) rd_data = scale_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      snap_q    <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) begin
        rsp_rdata <= rd_data;
        if (hit_half && half_idx == '0) begin
          snap_q <= count[INT_W-1:DATA_W];
        end
      end
    end
  end
endmodule

// File: rtl/sysctr_top.sv
module sysctr_top
  import sysctr_pkg::*;
#(
  parameter int INT_W   = 64,
  parameter int FRAC_W  = 24,
  parameter int DATA_W  = 32,
  parameter int SCALE_W = 32,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              req_valid,
  input  logic              req_wr,
  input  logic              req_frame,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int ACC_W      = INT_W + FRAC_W;
  localparam int NUM_HALVES = INT_W / DATA_W;
  localparam logic [SCALE_W-1:0] SCALE_ONE = SCALE_W'(1) << FRAC_W;

  logic                  wr_ctrl;
  logic                  ctrl_we;
  logic                  scale_we;
  logic                  rd_en;
  logic [NUM_HALVES-1:0] half_we;
  logic                  run;
  logic                  scale_en;
  logic [DATA_W-1:0]     ctrl_word;
  logic [SCALE_W-1:0]    scale_q;
  logic [INT_W-1:0]      count;
  logic [ACC_W-1:0]      acc_q;

  // writes to the status frame fall through every decode below
  assign wr_ctrl  = req_valid && req_wr && (req_frame == FRAME_CTRL);
  assign ctrl_we  = wr_ctrl && (req_addr == ADDR_W'(OFF_CTRL));
  assign scale_we = wr_ctrl && (req_addr == ADDR_W'(OFF_SCALE));
  assign rd_en    = req_valid && !req_wr;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half_we
    assign half_we[h] = wr_ctrl && (req_addr == ADDR_W'(OFF_CNT_BASE + h));
  end

  sysctr_ctrl_regs #(
    .DATA_W(DATA_W), .SCALE_W(SCALE_W), .SCALE_RST(SCALE_ONE)
  ) u_regs (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .scale_we(scale_we),
    .wdata(req_wdata), .run(run), .scale_en(scale_en),
    .ctrl_word(ctrl_word), .scale(scale_q)
  );

  sysctr_accum #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W), .SCALE_W(SCALE_W)
  ) u_acc (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .scale_en(scale_en),
    .scale(scale_q), .half_we(half_we), .wdata(req_wdata),
    .count(count), .acc(acc_q)
  );

  sysctr_readout #(
    .DATA_W(DATA_W), .INT_W(INT_W), .ADDR_W(ADDR_W)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_frame(req_frame),
    .rd_addr(req_addr), .ctrl_word(ctrl_word),
    .scale_word(DATA_W'(scale_q)), .count(count),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/sysctr_chk.sv
module sysctr_chk
  import sysctr_pkg::*;
#(
  parameter int INT_W   = 64,
  parameter int FRAC_W  = 24,
  parameter int DATA_W  = 32,
  parameter int SCALE_W = 32,
  parameter int ADDR_W  = 4,
  localparam int ACC_W      = INT_W + FRAC_W,
  localparam int NUM_HALVES = INT_W / DATA_W
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  tick,
  input logic                  req_valid,
  input logic                  req_wr,
  input logic                  req_frame,
  input logic [ADDR_W-1:0]     req_addr,
  input logic                  rsp_valid,
  input logic [1:0]            clksw_rd,
  input logic                  run,
  input logic                  scale_en,
  input logic [SCALE_W-1:0]    scale,
  input logic [NUM_HALVES-1:0] half_we,
  input logic [ACC_W-1:0]      acc
);
  logic rd_req, scl_wr, ctrl_rd;
  assign rd_req  = req_valid && !req_wr;
  assign scl_wr  = req_valid && req_wr && req_frame == FRAME_CTRL &&
                   req_addr == ADDR_W'(OFF_SCALE);
  assign ctrl_rd = rd_req && req_frame == FRAME_CTRL &&
                   req_addr == ADDR_W'(OFF_CTRL);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && acc == '0 && scale == (SCALE_W'(1) << FRAC_W)));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && half_we == '0) |=> acc == $past(acc));

  p_unit_step_r3: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !scale_en && half_we == '0) |=>
      acc == $past(acc) + (ACC_W'(1) << FRAC_W));

  p_scaled_step_r4: assert property (@(posedge clk) disable iff (rst)
    (run && tick && scale_en && half_we == '0) |=>
      acc == $past(acc) + ACC_W'($past(scale)));

  p_scale_lock_r5: assert property (@(posedge clk) disable iff (rst)
    (run && scl_wr) |=> scale == $past(scale));

  p_frac_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (half_we != '0) |=> acc[FRAC_W-1:0] == '0);

  p_clksw_zero_r8: assert property (@(posedge clk) disable iff (rst)
    ctrl_rd |=> clksw_rd == 2'b00);

  p_read_resp_r10: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rsp_valid);

  p_no_resp_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rsp_valid);
endmodule

bind sysctr_top sysctr_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W),
  .SCALE_W(SCALE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .req_valid(req_valid),
  .req_wr(req_wr), .req_frame(req_frame), .req_addr(req_addr),
  .rsp_valid(rsp_valid),
  .clksw_rd(rsp_rdata[sysctr_pkg::CTRL_CLKSW_LSB+1:sysctr_pkg::CTRL_CLKSW_LSB]),
  .run(run), .scale_en(scale_en), .scale(scale_q),
  .half_we(half_we), .acc(acc_q)
);

// File: tb/sysctr_top_tb.sv
module sysctr_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_wr = 1'b0;
  logic        req_frame = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int    n_checks = 0;
  int    n_err = 0;
  bit    done = 0;
  string cur_req = "R1";
  int    tick_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  sysctr_top u_dut (
    .clk(clk), .rst(rst), .tick(tick), .req_valid(req_valid),
    .req_wr(req_wr), .req_frame(req_frame), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // tick pattern: 0 off, 1 always, 2 pseudo-random
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tick = (tick_mode == 1) || (tick_mode == 2 && lfsr[0]);
  end

  // behavioural reference model
  logic [87:0] m_acc;
  logic [3:0]  m_keep;
  logic [31:0] m_scale, m_snap;
  logic [63:0] m_cnt;
  bit          exp_valid = 0;
  logic [31:0] exp_data = '0;
  bit          o_run, o_sen;
  logic [31:0] o_scale;

  always @(posedge clk) begin
    if (rst) begin
      m_acc = '0; m_keep = '0; m_scale = 32'h0100_0000; m_snap = '0;
      exp_valid = 0; exp_data = '0;
    end else begin
      m_cnt = m_acc[87:24];
      o_run = m_keep[0]; o_sen = m_keep[2]; o_scale = m_scale;
      exp_valid = req_valid && !req_wr;
      if (exp_valid) begin
        exp_data = 32'h0;
        if ((req_frame == 0 && req_addr == 2) || (req_frame == 1 && req_addr == 0)) begin
          exp_data = m_cnt[31:0];
          m_snap = m_cnt[63:32];
        end else if ((req_frame == 0 && req_addr == 3) || (req_frame == 1 && req_addr == 1))
          exp_data = m_snap;
        else if (req_frame == 0 && req_addr == 0)
          exp_data = {28'h0, m_keep};
        else if (req_frame == 0 && req_addr == 1)
          exp_data = m_scale;
      end
      if (req_valid && req_wr && req_frame == 0 && req_addr == 2)
        m_acc = {m_cnt[63:32], req_wdata, 24'h0};
      else if (req_valid && req_wr && req_frame == 0 && req_addr == 3)
        m_acc = {req_wdata, m_cnt[31:0], 24'h0};
      else if (o_run && tick)
        m_acc = m_acc + (o_sen ? {56'h0, o_scale} : 88'h100_0000);
      if (req_valid && req_wr && req_frame == 0 && req_addr == 0)
        m_keep = req_wdata[3:0];
      if (req_valid && req_wr && req_frame == 0 && req_addr == 1 && !o_run)
        m_scale = req_wdata;
    end
  end

  // cycle-by-cycle comparison of the response port
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_checks++;
      if (rsp_valid !== exp_valid || (exp_valid && rsp_rdata !== exp_data)) begin
        n_err++;
        $display("FAIL %s: rsp valid %0b data %h, expected valid %0b data %h",
                 cur_req, rsp_valid, rsp_rdata, exp_valid, exp_data);
      end
    end
  end

  task automatic bus_wr(input logic fr, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_wr = 1; req_frame = fr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_wr = 0;
  endtask

  task automatic bus_rd(input logic fr, input logic [3:0] a);
    @(negedge clk);
    req_valid = 1; req_wr = 0; req_frame = fr; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  // read with a hand-computed expectation
  task automatic rd_chk(input logic fr, input logic [3:0] a,
                        input logic [31:0] exp, input string tag);
    bus_rd(fr, a);
    n_checks++;
    if (rsp_rdata !== exp) begin
      n_err++;
      $display("FAIL %s: frame %0d offset %0d read %h, expected %h", tag, fr, a, rsp_rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 0;
    idle(2);

    cur_req = "R1";
    rd_chk(0, 0, 32'h0, "R1 control");
    rd_chk(0, 1, 32'h0100_0000, "R1 scale");
    rd_chk(0, 2, 32'h0, "R1 count low");
    rd_chk(0, 3, 32'h0, "R1 count high");
    rd_chk(1, 1, 32'h0, "R1 status high");

    cur_req = "R2";
    tick_mode = 1;
    bus_wr(0, 0, 32'h0000_000A);   // bits 1,3 set, run off
    idle(20);
    rd_chk(0, 2, 32'h0, "R2 stopped count");

    cur_req = "R8";
    bus_wr(0, 0, 32'hFFFF_FFFA);
    rd_chk(0, 0, 32'h0000_000A, "R8 control readback");
    bus_wr(0, 0, 32'h0000_0000);

    cur_req = "R10";
    rd_chk(0, 7, 32'h0, "R10 unused control offset");
    rd_chk(1, 5, 32'h0, "R10 unused status offset");

    cur_req = "R3";
    bus_wr(0, 0, 32'h1);
    idle(30);
    bus_rd(0, 2); bus_rd(0, 3);
    tick_mode = 2;
    bus_wr(0, 0, 32'hB);           // stored bits must not change the rate
    idle(40);
    bus_rd(0, 2); bus_rd(1, 0); bus_rd(1, 1);

    cur_req = "R4";
    bus_wr(0, 0, 32'h0);
    bus_wr(0, 1, 32'h0080_0000);   // half a count per tick
    rd_chk(0, 1, 32'h0080_0000, "R4 scale accepted while stopped");
    bus_wr(0, 0, 32'h5);
    idle(50);
    bus_rd(0, 2); bus_rd(0, 3);
    bus_wr(0, 0, 32'h0);
    bus_wr(0, 1, 32'h0340_0001);
    bus_wr(0, 0, 32'h5);
    tick_mode = 1;
    for (int i = 0; i < 10; i++) begin
      idle(7);
      bus_rd(0, 2);
    end

    cur_req = "R5";
    bus_wr(0, 1, 32'h0000_0007);
    rd_chk(0, 1, 32'h0340_0001, "R5 scale locked while running");

    cur_req = "R6";
    bus_wr(0, 0, 32'h0);
    bus_wr(0, 2, 32'hFFFF_FFF0);
    bus_wr(0, 3, 32'h0000_0001);
    rd_chk(0, 2, 32'hFFFF_FFF0, "R6 low half");
    rd_chk(0, 3, 32'h0000_0001, "R6 high half");
    bus_wr(0, 0, 32'h5);
    idle(5);
    bus_wr(0, 2, 32'h1234_5678);   // written while ticking
    bus_rd(0, 2); bus_rd(0, 3);

    cur_req = "R7";
    bus_wr(0, 0, 32'h0);
    bus_wr(0, 2, 32'hFFFF_FFFA);
    bus_wr(0, 3, 32'h0000_0010);
    bus_wr(0, 0, 32'h1);
    bus_rd(0, 2);
    idle(20);
    rd_chk(0, 3, 32'h0000_0010, "R7 captured high");
    rd_chk(1, 1, 32'h0000_0010, "R7 captured high via status");
    bus_rd(1, 0);
    rd_chk(1, 1, 32'h0000_0011, "R7 recapture after carry");

    cur_req = "R9";
    bus_wr(0, 0, 32'h0);
    bus_wr(0, 2, 32'h0000_0099);
    bus_wr(0, 3, 32'h0000_0000);
    bus_wr(1, 0, 32'hDEAD_BEEF);
    bus_wr(1, 1, 32'hDEAD_BEEF);
    rd_chk(1, 0, 32'h0000_0099, "R9 status write ignored low");
    rd_chk(1, 1, 32'h0000_0000, "R9 status write ignored high");

    cur_req = "R11";
    bus_wr(0, 2, 32'hFFFF_FFFE);
    bus_wr(0, 3, 32'hFFFF_FFFF);
    bus_wr(0, 0, 32'h1);
    idle(6);
    bus_rd(0, 2); bus_rd(0, 3);
    bus_wr(0, 0, 32'h0);
    bus_wr(0, 2, 32'hFFFF_FFFF);
    bus_wr(0, 3, 32'hFFFF_FFFF);
    bus_wr(0, 1, 32'h00FF_FFFF);
    bus_wr(0, 0, 32'h5);
    idle(4);
    bus_rd(0, 2); bus_rd(0, 3);
    tick_mode = 0;
    idle(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule